// File: doc/BRIEF.md
# Sixteen-Bit Timer with Wrap Flag and Clear-on-Compare

This block is a 16-bit up-counter that advances only on cycles where a timer clock enable is high. A 4-bit mode field selects how it counts. In free-running mode the counter rolls over from all-ones to zero. In one clear-on-compare mode the counter returns to zero after it reaches compare register A. In the other it returns to zero after it reaches a separate top/capture register. A sticky wrap flag records each rollover through all-ones. A sticky match flag records each tick on which the counter equals compare register A.

A single output channel drives a waveform pin. On a real compare match, a 2-bit action code decides what happens to the pin. Software can also apply the same action at once through a force strobe, without a real match. All configuration goes through one narrow write port: a 3-bit register select and a 16-bit data word. Software polls the two flags and clears them through the same port.

Top module: `tmr16_ctc`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: the count, both flags, the waveform pin, compare A and the top register. The mode is free-running and the action code is "none".
- R2: Write select 3 loads `wr_data[3:0]` as the mode. With mode 0, each cycle with `tick` high adds one to the count, and 0xFFFF wraps to 0x0000. With `tick` low the count holds.
- R3: The wrap flag sets on the same clock edge at which a tick takes the count from 0xFFFF to 0x0000, in any mode. Hardware never clears it. Writing select 6 with data bit 0 set clears it, but a set in the same cycle wins.
- R4: With mode 4, a tick while the count equals compare A (select 1) loads zero instead of count+1.
- R5: With mode 12, a tick while the count equals the top register (select 2) loads zero instead of count+1. Compare A then does not limit the count.
- R6: Every mode value other than 4 and 12 counts as mode 0.
- R7: A match is a cycle with `tick` high, the count equal to compare A, and no count write. A match sets the match flag. Writing select 6 with data bit 1 set clears the flag, and a set in the same cycle wins.
- R8: Select 4 loads `wr_data[1:0]` as the action code: 0 leaves the pin unchanged, 1 toggles it, 2 drives it low, 3 drives it high. A match applies the code to the pin on the same edge that sets the flag.
- R9: Writing a new action code does not change the pin. The new code is first used at the next match or force. A match in the same cycle as the write still uses the old code.
- R10: A write to select 5 (the data is ignored) forces the current action code onto the pin at that edge. It does not set the match flag and does not clear the count. A force and a match in the same cycle apply the action only once.
- R11: A write to select 0 loads `wr_data` into the count in any mode. It takes priority over the tick and suppresses that cycle's match and wrap. A write to select 7 has no effect.

Bit fields used by the port: mode is `wr_data[3:0]`, the action code is `wr_data[1:0]`, and the flag clears are `wr_data[0]` (wrap) and `wr_data[1]` (match).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 count, 1 compare A, 2 top, 3 mode, 4 action, 5 force, 6 flag clear, 7 reserved) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| wrap_flag | output | 1 | Sticky rollover flag |
| match_flag | output | 1 | Sticky compare-match flag |
| wave | output | 1 | Waveform pin |

## Verification
Several functions can land on the same clock edge, and each collision is resolved by a fixed rule:
- a hardware flag set and a software clear of that flag;
- a force and a real match;
- a count write and a match or wrap.

The bench provokes these collisions in directed steps. Examples are clearing the match flag on the very tick that matches, and forcing a toggle on a matching tick. A long random phase then reaches more collisions by keeping compare values small and loading the count near 0xFFFF. Each outcome is judged against a cycle model written from the requirements: set beats clear, a double action is applied once, and a count write beats the tick.

// File: rtl/tmr_pkg.sv
// Package: shared types and helpers for the 16-bit clear-on-compare timer.
// Assumes a 4-bit mode field and a 3-bit register select.
package tmr_pkg;

    localparam int MODE_W = 4;
    localparam int SEL_W  = 3;

    localparam logic [MODE_W-1:0] MODE_CTC_CMPA = 4'd4;
    localparam logic [MODE_W-1:0] MODE_CTC_TOPR = 4'd12;

    typedef enum logic [SEL_W-1:0] {
        SEL_CNT   = 3'd0,
        SEL_CMPA  = 3'd1,
        SEL_TOP   = 3'd2,
        SEL_MODE  = 3'd3,
        SEL_ACT   = 3'd4,
        SEL_FORCE = 3'd5,
        SEL_CLR   = 3'd6,
        SEL_RSVD  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_TOG  = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_HIGH = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        TOPSRC_NONE = 2'd0,
        TOPSRC_CMPA = 2'd1,
        TOPSRC_TOPR = 2'd2
    } top_src_e;

    // Map a mode value to the source of the counter top; unknown codes act as free-running.
    function automatic top_src_e decode_mode(input logic [MODE_W-1:0] m);
        case (m)
            MODE_CTC_CMPA: return TOPSRC_CMPA;
            MODE_CTC_TOPR: return TOPSRC_TOPR;
            default:       return TOPSRC_NONE;
        endcase
    endfunction

    // New pin level after applying an action code to the present level.
    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_TOG:  return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_regs.sv
// Register file: holds compare A, the top register, the mode and the action
// code, and turns port writes into one-cycle strobes (count load, force,
// flag clears). Assumes one write per cycle; select 7 is ignored.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cmpa,
    output logic [CNT_W-1:0] top_reg,
    output top_src_e         top_src,
    output act_e             act,
    output logic             load_cnt,
    output logic             force_stb,
    output logic             clr_wrap,
    output logic             clr_match
);

    logic [MODE_W-1:0] mode_q;
    logic              hit_cmpa, hit_top, hit_mode, hit_act, hit_clr;

    // Decode the write select into per-register enables.
    always_comb begin
        load_cnt  = wr_en && (wr_sel == SEL_CNT);
        hit_cmpa  = wr_en && (wr_sel == SEL_CMPA);
        hit_top   = wr_en && (wr_sel == SEL_TOP);
        hit_mode  = wr_en && (wr_sel == SEL_MODE);
        hit_act   = wr_en && (wr_sel == SEL_ACT);
        force_stb = wr_en && (wr_sel == SEL_FORCE);
        hit_clr   = wr_en && (wr_sel == SEL_CLR);
        clr_wrap  = hit_clr && wr_data[0];
        clr_match = hit_clr && wr_data[1];
    end

    // Store configuration registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa    <= '0;
            top_reg <= '0;
            mode_q  <= '0;
            act     <= ACT_NONE;
        end else begin
            if (hit_cmpa) cmpa    <= wr_data;
            if (hit_top)  top_reg <= wr_data;
            if (hit_mode) mode_q  <= wr_data[MODE_W-1:0];
            if (hit_act)  act     <= act_e'(wr_data[1:0]);
        end
    end

    // Select the counter top source from the stored mode.
    always_comb top_src = decode_mode(mode_q);

    a_r6_mode_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_CTC_CMPA && mode_q != MODE_CTC_TOPR) |-> top_src == TOPSRC_NONE);

    a_r9_act_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_act |=> $stable(act));

endmodule

// File: rtl/tmr_count.sv
// Counter core: advances on tick, clears after reaching the selected top in
// the clear-on-compare modes, takes software loads with top priority, and
// keeps the sticky wrap flag (hardware set wins over software clear).
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  top_src_e         top_src,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] top_reg,
    input  logic             clr_wrap,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_flag
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic at_top, wrap_now, adv;

    // Decide whether the count sits at the active top and whether this tick wraps.
    always_comb begin
        case (top_src)
            TOPSRC_CMPA: at_top = (cnt == cmpa);
            TOPSRC_TOPR: at_top = (cnt == top_reg);
            default:     at_top = 1'b0;
        endcase
        adv      = tick && !load;
        wrap_now = adv && (cnt == MAXV);
    end

    // Update the count: load first, then clear at top, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= load_val;
        else if (tick)    cnt <= at_top ? '0 : cnt + 1'b1;
    end

    // Sticky rollover flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        wrap_flag <= 1'b0;
        else if (wrap_now) wrap_flag <= 1'b1;
        else if (clr_wrap) wrap_flag <= 1'b0;
    end

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && top_src == TOPSRC_NONE) |=> cnt == $past(cnt) + 1'b1);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    a_r3_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt == MAXV) |=> (wrap_flag && cnt == '0));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flag && !clr_wrap) |=> wrap_flag);

    a_r4_clear_at_cmpa: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && top_src == TOPSRC_CMPA && cnt == cmpa) |=> cnt == '0);

    a_r5_clear_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && top_src == TOPSRC_TOPR && cnt == top_reg) |=> cnt == '0);

endmodule

// File: rtl/tmr_outcmp.sv
// Compare-output unit: detects a match of the count with compare A on a
// tick (suppressed by a count load), keeps the sticky match flag and drives
// the waveform pin from the action code on a match or a force.
// Assumes a force is a one-cycle strobe; force plus match acts once.
module tmr_outcmp
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmpa,
    input  act_e             act,
    input  logic             force_stb,
    input  logic             clr_match,
    output logic             match,
    output logic             match_flag,
    output logic             wave
);

    // Qualify an equality as a real match.
    always_comb match = tick && !load && (cnt == cmpa);

    // Sticky match flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         match_flag <= 1'b0;
        else if (match)     match_flag <= 1'b1;
        else if (clr_match) match_flag <= 1'b0;
    end

    // Apply the action code to the pin once per match or force.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wave <= 1'b0;
        else if (match || force_stb) wave <= apply_act(act, wave);
    end

    a_r7_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> match_flag);

    a_r8_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(match || force_stb) |=> $stable(wave));

    a_r8_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_NONE) |=> $stable(wave));

    a_r10_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !match && !match_flag) |=> !match_flag);

endmodule

// File: rtl/tmr16_ctc.sv
// Top: 16-bit timer with free-running and two clear-on-compare modes, a
// sticky wrap flag, a sticky match flag and one waveform output. Assumes
// the tick input is already synchronous to clk.
module tmr16_ctc
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             wrap_flag,
    output logic             match_flag,
    output logic             wave
);

    logic [CNT_W-1:0] cmpa, top_reg;
    top_src_e         top_src;
    act_e             act;
    logic             load_cnt, force_stb, clr_wrap, clr_match, match;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cmpa      (cmpa),
        .top_reg   (top_reg),
        .top_src   (top_src),
        .act       (act),
        .load_cnt  (load_cnt),
        .force_stb (force_stb),
        .clr_wrap  (clr_wrap),
        .clr_match (clr_match)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load_cnt),
        .load_val  (wr_data),
        .top_src   (top_src),
        .cmpa      (cmpa),
        .top_reg   (top_reg),
        .clr_wrap  (clr_wrap),
        .cnt       (count),
        .wrap_flag (wrap_flag)
    );

    tmr_outcmp #(.CNT_W(CNT_W)) u_outcmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load_cnt),
        .cnt        (count),
        .cmpa       (cmpa),
        .act        (act),
        .force_stb  (force_stb),
        .clr_match  (clr_match),
        .match      (match),
        .match_flag (match_flag),
        .wave       (wave)
    );

    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CNT) |=> count == $past(wr_data));

    a_r11_load_blocks_match: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CNT) |-> !match);

    a_r10_force_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !tick) |=> count == $past(count));

endmodule

// File: tb/tmr16_ctc_tb.sv
`timescale 1ns/1ps
module tmr16_ctc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] count;
    logic        wrap_flag, match_flag, wave;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    tmr16_ctc u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count(count), .wrap_flag(wrap_flag),
        .match_flag(match_flag), .wave(wave)
    );

    // Reference state built from the requirements.
    logic [15:0] m_cnt, m_cmpa, m_top;
    logic [3:0]  m_mode;
    logic [1:0]  m_act;
    logic        m_wrap, m_match, m_wave;

    task automatic model_reset();
        m_cnt = 0; m_cmpa = 0; m_top = 0; m_mode = 0; m_act = 0;
        m_wrap = 0; m_match = 0; m_wave = 0;
    endtask

    function automatic logic act_pin(input logic [1:0] a, input logic cur);
        case (a)
            2'd1: return ~cur;
            2'd2: return 1'b0;
            2'd3: return 1'b1;
            default: return cur;
        endcase
    endfunction

    // One clock edge of the model, given the inputs present at that edge.
    task automatic model_edge(input logic t, input logic we, input logic [2:0] s, input logic [15:0] d);
        logic ld, mt, fc, wr, at_top;
        ld = we && s == 3'd0;
        mt = t && !ld && m_cnt == m_cmpa;
        fc = we && s == 3'd5;
        wr = t && !ld && m_cnt == 16'hFFFF;
        at_top = (m_mode == 4'd4 && m_cnt == m_cmpa) || (m_mode == 4'd12 && m_cnt == m_top);
        if (mt || fc) m_wave = act_pin(m_act, m_wave);
        if (mt) m_match = 1;
        else if (we && s == 3'd6 && d[1]) m_match = 0;
        if (wr) m_wrap = 1;
        else if (we && s == 3'd6 && d[0]) m_wrap = 0;
        if (ld) m_cnt = d;
        else if (t) m_cnt = at_top ? 16'd0 : m_cnt + 16'd1;
        if (we && s == 3'd1) m_cmpa = d;
        if (we && s == 3'd2) m_top = d;
        if (we && s == 3'd3) m_mode = d[3:0];
        if (we && s == 3'd4) m_act = d[1:0];
    endtask

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "count", count, m_cnt);
        chk(tag, "wrap_flag", {15'd0, wrap_flag}, {15'd0, m_wrap});
        chk(tag, "match_flag", {15'd0, match_flag}, {15'd0, m_match});
        chk(tag, "wave", {15'd0, wave}, {15'd0, m_wave});
    endtask

    // Drive one cycle of inputs, advance the model, and check after the edge.
    task automatic step(input string tag, input logic t, input logic we, input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        tick = t; wr_en = we; wr_sel = s; wr_data = d;
        model_edge(t, we, s, d);
        @(posedge clk);
        #1;
        tick = 0; wr_en = 0;
        check_all(tag);
    endtask

    task automatic wr(input string tag, input logic [2:0] s, input logic [15:0] d);
        step(tag, 1'b0, 1'b1, s, d);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] dv;
        logic [2:0]  sv;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "count", count, 16'h0000);
        chk("R1", "flags", {14'd0, wrap_flag, match_flag}, 16'd0);
        chk("R1", "wave", {15'd0, wave}, 16'd0);

        // R2: free-running count, hold without tick
        wr("R1", 3'd1, 16'h0100);
        for (int i = 0; i < 5; i++) step("R2", 1'b1, 1'b0, 3'd0, 16'd0);
        chk("R2", "count after 5 ticks", count, 16'd5);
        for (int i = 0; i < 3; i++) step("R2", 1'b0, 1'b0, 3'd0, 16'd0);

        // R3: wrap on 0xFFFF -> 0, then clear colliding with set
        wr("R11", 3'd0, 16'hFFFE);
        step("R3", 1'b1, 1'b0, 3'd0, 16'd0);
        step("R3", 1'b1, 1'b0, 3'd0, 16'd0);
        chk("R3", "wrap set", {15'd0, wrap_flag}, 16'd1);
        wr("R3", 3'd6, 16'h0001);
        chk("R3", "wrap cleared", {15'd0, wrap_flag}, 16'd0);
        wr("R11", 3'd0, 16'hFFFF);
        step("R3", 1'b1, 1'b1, 3'd6, 16'h0001);
        chk("R3", "set beats clear", {15'd0, wrap_flag}, 16'd1);

        // R11: count write suppresses wrap
        wr("R3", 3'd6, 16'h0003);
        wr("R11", 3'd0, 16'hFFFF);
        step("R11", 1'b1, 1'b1, 3'd0, 16'h0010);
        chk("R11", "no wrap on load", {15'd0, wrap_flag}, 16'd0);

        // R4: clear at compare A, match flag, toggle pin
        wr("R8", 3'd4, 16'd1);
        wr("R4", 3'd1, 16'd3);
        wr("R4", 3'd3, 16'd4);
        wr("R11", 3'd0, 16'd0);
        for (int i = 0; i < 9; i++) step("R4", 1'b1, 1'b0, 3'd0, 16'd0);
        chk("R7", "match flag", {15'd0, match_flag}, 16'd1);
        // R7: clear on matching tick loses
        wr("R11", 3'd0, 16'd3);
        step("R7", 1'b1, 1'b1, 3'd6, 16'h0002);
        chk("R7", "set beats clear", {15'd0, match_flag}, 16'd1);
        // R11: count write blocks match
        wr("R7", 3'd6, 16'h0002);
        wr("R11", 3'd0, 16'd3);
        step("R11", 1'b1, 1'b1, 3'd0, 16'd3);
        chk("R11", "no match on load", {15'd0, match_flag}, 16'd0);

        // R5: top register sets period
        wr("R5", 3'd2, 16'd6);
        wr("R5", 3'd3, 16'd12);
        wr("R11", 3'd0, 16'd0);
        for (int i = 0; i < 15; i++) step("R5", 1'b1, 1'b0, 3'd0, 16'd0);

        // R6: unsupported mode counts past compare A
        wr("R6", 3'd3, 16'd7);
        wr("R11", 3'd0, 16'd2);
        for (int i = 0; i < 4; i++) step("R6", 1'b1, 1'b0, 3'd0, 16'd0);
        chk("R6", "no clear", count, 16'd6);

        // R9: action write leaves pin alone until next match
        wr("R9", 3'd4, 16'd3);
        wr("R9", 3'd4, 16'd2);
        wr("R9", 3'd4, 16'd3);
        wr("R11", 3'd0, 16'd3);
        step("R9", 1'b1, 1'b1, 3'd4, 16'd2);
        // R10: force without match, and force on matching tick acts once
        wr("R10", 3'd4, 16'd1);
        wr("R10", 3'd5, 16'hFFFF);
        wr("R10", 3'd5, 16'h0000);
        wr("R7", 3'd6, 16'h0002);
        wr("R11", 3'd0, 16'd3);
        step("R10", 1'b1, 1'b1, 3'd5, 16'd0);
        wr("R11", 3'd7, 16'h1234);
        wr("R10", 3'd3, 16'd4);
        wr("R11", 3'd0, 16'd3);
        step("R10", 1'b0, 1'b1, 3'd5, 16'd0);
        chk("R10", "force keeps count", count, 16'd3);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            sv = 3'($urandom_range(0, 7));
            dv = 16'($urandom);
            case (sv)
                3'd0: dv = ($urandom_range(0, 3) == 0) ? (16'hFFF0 | dv[3:0]) : {8'd0, dv[7:0]};
                3'd1, 3'd2: dv = {10'd0, dv[5:0]};
                3'd3: case ($urandom_range(0, 3))
                          0: dv = 16'd0;
                          1: dv = 16'd4;
                          2: dv = 16'd12;
                          default: dv = dv;
                      endcase
                default: ;
            endcase
            step("R8", ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0), sv, dv);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule